// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is an SPI master that a host drives through seven 8-bit registers on a simple synchronous bus. Writing a byte to the data register queues it. The shift engine then sends it MSB first on `mosi` while it collects the byte arriving on `miso`. The host reads the collected byte back through the same address. Clock polarity and phase can be programmed. The serial clock is the system clock divided by a power of two, chosen by a 4-bit code. The low half of that code is in the control register and the high half is in the extended register.

Four chip-select outputs are set directly by software. Each line has its own enable bit and its own level bit. The transmit side holds up to four bytes and the receive side holds two. Status flags show both queues. A mode-fault input stops master operation and raises an interrupt. The parameter and timing registers are plain storage for the host. The memory-mapped read enable in the parameter register is held but has no function.

Register addresses: 0 control, 1 status, 2 data, 3 extended, 4 parameter, 5 chip-select, 6 timing. Address 7 reads as zero.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the registers read as follows: control, extended, parameter, chip-select and timing read 0x00, and status reads 0x09. All chip-select outputs are high, `sclk` is low and `irq` is low.
- R2: The divider code is {extended[1:0], control[1:0]}. It divides the clock as follows: code 0 by 2, code 4 by 8, code 1 by 4, code 2 by 16, code 3 by 32, and code 5 through 11 by 64, 128, and so on up to 4096. During a byte, each half period of `sclk` lasts half the divisor in clock cycles.
- R3: Control bit 3 is the polarity and sets the idle level of `sclk`. Control bit 2 is the phase. With phase 0, data is captured on the leading edge. With phase 1, data is captured on the trailing edge. All four combinations exchange bytes correctly.
- R4: Writing the data register (address 2) starts a full-duplex 8-bit exchange, MSB first. Reading address 2 returns and removes the oldest received byte.
- R5: Status bit 0 is set while no received byte is waiting. Bit 1 is set when the receive side is full. Bit 3 is set when the transmit side is empty. Bit 4 is set while a byte is shifting. Bit 5 always reads 0.
- R6: The transmit side holds four bytes, and status bit 2 is set when it is full. A data write while it is full is discarded and sets status bit 6. Writing 1 to status bit 6 clears it.
- R7: The receive side holds two bytes. A byte that completes while two are already waiting, with no read in that cycle, is discarded.
- R8: For each line n in 0..3, if chip-select bit n is 0 then `cs_n[n]` is 1. If bit n is 1, then `cs_n[n]` follows chip-select bit n+4.
- R9: While control bit 6 (enable) is 0, data writes are ignored and `sclk` stays at the polarity level.
- R10: While control bits 6 and 4 (enable and master) are both set, a low `fault_n` does three things: it sets status bit 7, raises `irq` and clears control bit 4. Writing 1 to status bit 7 clears the flag and `irq`. While bit 4 is clear, queued bytes wait.
- R11: The extended, parameter and timing registers read back the value that was written to them.
- R12: Codes 12 through 15 divide by 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the serial clock reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Register read strobe (pops data at address 2) |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Mode-fault interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| fault_n | input | 1 | Active-low mode-fault input |
| cs_n | output | 4 | Software chip-select lines |

## Verification
Two events can land in the same cycle. The first is a host write to the data register in the same cycle that the shift engine takes the head of the transmit queue. The second is a completed receive byte arriving in the same cycle as a host read.

The bench provokes the first with a burst of six data writes on consecutive cycles at the fastest divider. If the pop and push are counted correctly, only the sixth write collides. A status read right after the burst must be exactly busy, full, collision and receive-empty. After the burst drains, the bench requires exactly the first two slave bytes in the receive queue, with all five transmitted bytes seen by the slave.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 12;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_DATA  = 3'd2;
  localparam logic [2:0] A_EXT   = 3'd3;
  localparam logic [2:0] A_PARAM = 3'd4;
  localparam logic [2:0] A_CSEL  = 3'd5;
  localparam logic [2:0] A_TIME  = 3'd6;

  // control bit positions
  localparam int C_EN   = 6;
  localparam int C_MST  = 4;
  localparam int C_CPOL = 3;
  localparam int C_CPHA = 2;

  // status bit positions
  localparam int S_RXE  = 0;
  localparam int S_RXF  = 1;
  localparam int S_TXF  = 2;
  localparam int S_TXE  = 3;
  localparam int S_BSY  = 4;
  localparam int S_WCOL = 6;
  localparam int S_FLT  = 7;

  // log2 of the serial clock divisor for a 4-bit code
  function automatic logic [3:0] div_exp(input logic [3:0] code);
    logic [3:0] e;
    case (code)
      4'd0:    e = 4'd1;
      4'd1:    e = 4'd2;
      4'd4:    e = 4'd3;
      4'd2:    e = 4'd4;
      4'd3:    e = 4'd5;
      4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11:
               e = code + 4'd1;
      default: e = 4'd12;
    endcase
    return e;
  endfunction

  // clock cycles per half period of the serial clock
  function automatic logic [HALF_W-1:0] half_period(input logic [3:0] code);
    return HALF_W'(1) << (div_exp(code) - 4'd1);
  endfunction

endpackage

// File: rtl/spi_rm_fifo.sv
module spi_rm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

endmodule

// File: rtl/spi_rm_clkgen.sv
module spi_rm_clkgen
  import spi_rm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [3:0] code,
  output logic       tick
);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half;

  assign half = half_period(code);
  assign tick = active && (cnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!active || tick) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine
  import spi_rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tick,
  input  logic              tx_avail,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              start,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam int EDGES = 2 * BYTE_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [EW-1:0]     edge_cnt;
  logic              phase;
  logic [BYTE_W-1:0] shreg, rxsh;
  logic              sample_now, shift_now;

  assign start      = run && !busy && tx_avail;
  assign sample_now = (edge_cnt[0] == cpha);
  assign shift_now  = !sample_now && (edge_cnt != '0) && (edge_cnt != LAST);
  assign rx_push    = busy && tick && (edge_cnt == LAST);
  assign rx_byte    = sample_now ? {rxsh[BYTE_W-2:0], miso} : rxsh;
  assign sclk       = cpol ^ phase;
  assign mosi       = shreg[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= 1'b0;
      edge_cnt <= '0;
      shreg    <= '0;
      rxsh     <= '0;
    end else if (!run) begin
      busy     <= 1'b0;
      phase    <= 1'b0;
      edge_cnt <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      phase    <= 1'b0;
      edge_cnt <= '0;
      shreg    <= tx_byte;
    end else if (busy && tick) begin
      phase    <= ~phase;
      edge_cnt <= edge_cnt + 1'b1;
      if (sample_now) rxsh  <= {rxsh[BYTE_W-2:0], miso};
      if (shift_now)  shreg <= {shreg[BYTE_W-2:0], 1'b0};
      if (edge_cnt == LAST) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_rm_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 2,
  parameter int CS_LINES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [7:0]          reg_wdata,
  input  logic                reg_rd,
  output logic [7:0]          reg_rdata,
  output logic                irq,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  input  logic                fault_n,
  output logic [CS_LINES-1:0] cs_n
);

  logic [7:0] ctrl_q, ext_q, param_q, cs_q, time_q;
  logic       wcol_q, fault_q;

  logic en, run, cpol, cpha;
  logic [3:0] code;
  logic data_wr, tx_push, wcol_set, host_pop, fault_evt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [BYTE_W-1:0] tx_head, rx_head, eng_rx_byte;
  logic eng_start, eng_busy, eng_rx_push, rx_accept, tick;

  assign en   = ctrl_q[C_EN];
  assign run  = en && ctrl_q[C_MST];
  assign cpol = ctrl_q[C_CPOL];
  assign cpha = ctrl_q[C_CPHA];
  assign code = {ext_q[1:0], ctrl_q[1:0]};

  assign data_wr   = reg_wr && (reg_addr == A_DATA) && en;
  assign tx_push   = data_wr && !tx_full;
  assign wcol_set  = data_wr && tx_full;
  assign host_pop  = reg_rd && (reg_addr == A_DATA) && !rx_empty;
  assign fault_evt = run && !fault_n;
  assign rx_accept = eng_rx_push && (!rx_full || host_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ext_q   <= '0;
      param_q <= '0;
      cs_q    <= '0;
      time_q  <= '0;
      wcol_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL:  ctrl_q  <= reg_wdata;
          A_EXT:   ext_q   <= reg_wdata;
          A_PARAM: param_q <= reg_wdata;
          A_CSEL:  cs_q    <= reg_wdata;
          A_TIME:  time_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (fault_evt) ctrl_q[C_MST] <= 1'b0;

      if (wcol_set) wcol_q <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[S_WCOL]) wcol_q <= 1'b0;

      if (fault_evt) fault_q <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[S_FLT]) fault_q <= 1'b0;
    end
  end

  spi_rm_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .pop(eng_start), .din(reg_wdata),
    .dout(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spi_rm_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_accept), .pop(host_pop), .din(eng_rx_byte),
    .dout(rx_head), .full(rx_full), .empty(rx_empty)
  );

  spi_rm_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .active(eng_busy), .code(code), .tick(tick)
  );

  spi_rm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .cpha(cpha),
    .tick(tick), .tx_avail(!tx_empty), .tx_byte(tx_head), .miso(miso),
    .start(eng_start), .busy(eng_busy), .sclk(sclk), .mosi(mosi),
    .rx_push(eng_rx_push), .rx_byte(eng_rx_byte)
  );

  for (genvar g = 0; g < CS_LINES; g++) begin : g_cs
    assign cs_n[g] = cs_q[g] ? cs_q[g + 4] : 1'b1;
  end

  logic [7:0] status;
  always_comb begin
    status         = '0;
    status[S_RXE]  = rx_empty;
    status[S_RXF]  = rx_full;
    status[S_TXF]  = tx_full;
    status[S_TXE]  = tx_empty;
    status[S_BSY]  = eng_busy;
    status[S_WCOL] = wcol_q;
    status[S_FLT]  = fault_q;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = status;
      A_DATA:  reg_rdata = rx_head;
      A_EXT:   reg_rdata = ext_q;
      A_PARAM: reg_rdata = param_q;
      A_CSEL:  reg_rdata = cs_q;
      A_TIME:  reg_rdata = time_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = fault_q;

endmodule

// File: rtl/spi_rm_chk.sv
module spi_rm_chk #(
  parameter int CS_LINES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                start,
  input logic                sclk,
  input logic                cpol,
  input logic                data_wr,
  input logic                tx_full,
  input logic                wcol,
  input logic                rx_full,
  input logic                host_pop,
  input logic                eng_rx_push,
  input logic                fault_evt,
  input logic                irq,
  input logic [7:0]          cs_reg,
  input logic [CS_LINES-1:0] cs_n
);

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R6
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_full) |=> wcol);

  // R7
  rx_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && host_pop && !eng_rx_push) |=> !rx_full);

  // R10
  fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> irq);

  // R8
  cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cs_reg[CS_LINES-1:0]) & ~cs_n) == '0);

endmodule

bind spi_regmaster spi_rm_chk #(.CS_LINES(CS_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .start(eng_start),
  .sclk(sclk), .cpol(cpol), .data_wr(data_wr), .tx_full(tx_full),
  .wcol(wcol_q), .rx_full(rx_full), .host_pop(host_pop),
  .eng_rx_push(eng_rx_push), .fault_evt(fault_evt), .irq(irq),
  .cs_reg(cs_q), .cs_n(cs_n)
);

// File: tb/spi_regmaster_tb_top.sv
module spi_regmaster_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, sclk, mosi;
  logic       miso = 1'b1;
  logic       fault_n = 1'b1;
  logic [3:0] cs_n;

  spi_regmaster dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso),
    .fault_n(fault_n), .cs_n(cs_n)
  );

  int total = 0, bad = 0;
  int pc_total = 0, pc_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model: chip selects, irq, control ----------
  logic [3:0] exp_cs = 4'hF;
  logic       exp_irq = 1'b0;
  logic [7:0] sh_ctrl = 8'h00;
  bit         model_on = 1'b0;

  function automatic logic [3:0] cs_expect(input logic [7:0] r);
    logic [3:0] v;
    for (int n = 0; n < 4; n++) v[n] = r[n] ? r[n + 4] : 1'b1;
    return v;
  endfunction

  always @(negedge clk) begin
    if (model_on) begin
      pc_total += 2;
      if (cs_n !== exp_cs) begin
        pc_bad++;
        $display("FAIL R8 cs_n per-cycle actual=0x%0h expected=0x%0h", cs_n, exp_cs);
      end
      if (irq !== exp_irq) begin
        pc_bad++;
        $display("FAIL R10 irq per-cycle actual=0x%0h expected=0x%0h", irq, exp_irq);
      end
    end
  end

  // ---------------- half-period monitor ----------------
  int   meas_min = 0, meas_max = 0, mcnt = 0;
  bit   have_prev = 0, meas_req = 0, meas_seen = 0;
  logic m_prev = 1'b0;

  always @(negedge clk) begin
    if (meas_req != meas_seen) begin
      meas_seen = meas_req;
      have_prev = 0;
      meas_min  = 1 << 20;
      meas_max  = 0;
    end
    if (sclk !== m_prev) begin
      if (have_prev) begin
        if (mcnt + 1 < meas_min) meas_min = mcnt + 1;
        if (mcnt + 1 > meas_max) meas_max = mcnt + 1;
      end
      have_prev = 1;
      mcnt = 0;
    end else begin
      mcnt++;
    end
    m_prev = sclk;
  end

  // ---------------- behavioural SPI slave ----------------
  logic [7:0] slv_out[$];
  logic [7:0] slv_got[$];
  logic [7:0] ob = 8'hFF, rsh = 8'h00;
  int         ns = 0;
  bit         kick = 0, kick_seen = 0;
  bit         m_cpol = 0, m_cpha = 0;

  always @(sclk, kick) begin
    if (kick != kick_seen) begin
      kick_seen = kick;
      ns = 0;
      if (slv_out.size() > 0) ob = slv_out.pop_front();
      else ob = 8'hFF;
      miso = ob[7];
    end else if (sclk === 1'b0 || sclk === 1'b1) begin
      if ((sclk === 1'b1) == (m_cpol == m_cpha)) begin
        rsh = {rsh[6:0], mosi};
        ns++;
        if (ns == 8) begin
          slv_got.push_back(rsh);
          ns = 0;
          if (slv_out.size() > 0) ob = slv_out.pop_front();
          else ob = 8'hFF;
          miso = ob[7];
        end
      end else begin
        miso = ob[7 - ns];
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    if (a == 3'd5) exp_cs = cs_expect(d);
    if (a == 3'd1 && d[7]) exp_irq = 1'b0;
    if (a == 3'd0) sh_ctrl = d;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic slave_prep();
    kick = ~kick;
    #1;
  endtask

  task automatic wait_status(input logic [7:0] mask, input logic [7:0] val, output bit ok);
    logic [7:0] s;
    ok = 0;
    for (int i = 0; i < 40000; i++) begin
      rd(3'd1, s);
      if ((s & mask) == val) begin ok = 1; break; end
    end
  endtask

  function automatic int exp_half(input int c);
    int divs[16] = '{2, 4, 16, 32, 8, 64, 128, 256, 512, 1024, 2048,
                     4096, 4096, 4096, 4096, 4096};
    return divs[c] / 2;
  endfunction

  task automatic set_mode(input logic [7:0] c, input logic [7:0] e);
    wr(3'd0, c);
    wr(3'd3, e);
    m_cpol = c[3];
    m_cpha = c[2];
    repeat (2) @(posedge clk);
  endtask

  task automatic do_xfer(input logic [7:0] c, input logic [7:0] e,
                         input logic [7:0] tx, input logic [7:0] srx,
                         input string tag);
    logic [7:0] v;
    bit ok;
    int n0, eh;
    set_mode(c, e);
    eh = exp_half(int'({e[1:0], c[1:0]}));
    slv_out.push_back(srx);
    slave_prep();
    meas_req = ~meas_req;
    n0 = slv_got.size();
    wr(3'd2, tx);
    wait_status(8'h01, 8'h00, ok);
    chk(ok, {tag, " R5 rx byte becomes available"}, ok, 1);
    rd(3'd2, v);
    chk(v == srx, {tag, " R4 received byte"}, v, srx);
    chk(slv_got.size() == n0 + 1, {tag, " R4 slave byte count"}, slv_got.size(), n0 + 1);
    if (slv_got.size() == n0 + 1)
      chk(slv_got[n0] == tx, {tag, " R4 transmitted byte"}, slv_got[n0], tx);
    chk(meas_min == eh && meas_max == eh, {tag, " R2 half period"}, meas_max, eh);
    chk(sclk == c[3], {tag, " R3 idle level"}, sclk, c[3]);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog R1..R12 actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total + pc_total + 1, bad + pc_bad + 1);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] v;
    bit ok;
    int n0;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    model_on = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk(v == 8'h00, "R1 control reset", v, 8'h00);
    rd(3'd1, v); chk(v == 8'h09, "R1 R5 status reset", v, 8'h09);
    rd(3'd3, v); chk(v == 8'h00, "R1 extended reset", v, 8'h00);
    rd(3'd4, v); chk(v == 8'h00, "R1 parameter reset", v, 8'h00);
    rd(3'd5, v); chk(v == 8'h00, "R1 chip-select reset", v, 8'h00);
    rd(3'd6, v); chk(v == 8'h00, "R1 timing reset", v, 8'h00);
    chk(cs_n == 4'hF, "R1 cs_n reset", cs_n, 4'hF);
    chk(sclk == 1'b0, "R1 sclk reset", sclk, 0);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);

    // R11 plain storage registers
    wr(3'd0, 8'h51); wr(3'd3, 8'h00); wr(3'd6, 8'h01); wr(3'd4, 8'h40);
    rd(3'd0, v); chk(v == 8'h51, "R11 control readback", v, 8'h51);
    rd(3'd6, v); chk(v == 8'h01, "R11 timing readback", v, 8'h01);
    rd(3'd4, v); chk(v == 8'h40, "R11 parameter readback", v, 8'h40);
    wr(3'd3, 8'hA2); rd(3'd3, v); chk(v == 8'hA2, "R11 extended readback", v, 8'hA2);

    // R2 R3 R4 all four modes, several codes
    do_xfer(8'h51, 8'h00, 8'hA5, 8'h3C, "mode0 code1");
    do_xfer(8'h54, 8'h01, 8'h5A, 8'hC3, "mode1 code4");
    do_xfer(8'h5A, 8'h00, 8'h81, 8'h7E, "mode2 code2");
    do_xfer(8'h5F, 8'h00, 8'h0F, 8'hF0, "mode3 code3");
    do_xfer(8'h50, 8'h00, 8'h6B, 8'h94, "mode0 code0");
    do_xfer(8'h51, 8'h02, 8'h96, 8'h69, "mode0 code9");
    do_xfer(8'h53, 8'h03, 8'h33, 8'hCC, "R12 code15");

    // R8 chip selects
    wr(3'd5, 8'h23);
    chk(cs_n == 4'b1110, "R8 cs pattern 0x23", cs_n, 4'b1110);
    wr(3'd5, 8'hCF);
    chk(cs_n == 4'b1100, "R8 cs pattern 0xCF", cs_n, 4'b1100);
    wr(3'd5, 8'h00);

    // R9 disabled block ignores data writes
    set_mode(8'h18, 8'h00);
    n0 = slv_got.size();
    chk(sclk == 1'b1, "R9 sclk idle while disabled", sclk, 1);
    wr(3'd2, 8'h77);
    repeat (40) @(posedge clk);
    rd(3'd1, v); chk(v == 8'h09, "R9 status after ignored write", v, 8'h09);
    chk(sclk == 1'b1, "R9 sclk held", sclk, 1);
    chk(slv_got.size() == n0, "R9 no exchange", slv_got.size(), n0);

    // R6 R7 burst: write collides only on the sixth byte
    set_mode(8'h50, 8'h00);
    slv_out.push_back(8'h11); slv_out.push_back(8'h22); slv_out.push_back(8'h33);
    slv_out.push_back(8'h44); slv_out.push_back(8'h55);
    slave_prep();
    n0 = slv_got.size();
    for (int i = 0; i < 6; i++) wr(3'd2, 8'hA1 + 8'(i));
    rd(3'd1, v); chk(v == 8'h55, "R6 R5 status after burst", v, 8'h55);
    wait_status(8'h18, 8'h08, ok);
    chk(ok, "R6 burst drains", ok, 1);
    rd(3'd1, v); chk(v == 8'h4A, "R7 status with receive full", v, 8'h4A);
    rd(3'd2, v); chk(v == 8'h11, "R7 first kept byte", v, 8'h11);
    rd(3'd2, v); chk(v == 8'h22, "R7 second kept byte", v, 8'h22);
    rd(3'd1, v); chk(v == 8'h49, "R7 later bytes dropped", v, 8'h49);
    chk(slv_got.size() == n0 + 5, "R6 five bytes sent", slv_got.size(), n0 + 5);
    if (slv_got.size() == n0 + 5)
      for (int i = 0; i < 5; i++)
        chk(slv_got[n0 + i] == 8'hA1 + 8'(i), "R6 sent byte order", slv_got[n0 + i], 8'hA1 + i);
    wr(3'd1, 8'h40);
    rd(3'd1, v); chk(v == 8'h09, "R6 collision cleared", v, 8'h09);

    // R10 mode fault
    set_mode(8'h51, 8'h00);
    @(negedge clk) fault_n = 1'b0;
    @(posedge clk);
    #1 exp_irq = 1'b1;
    sh_ctrl[4] = 1'b0;
    fault_n = 1'b1;
    rd(3'd0, v); chk(v == 8'h41, "R10 master bit cleared", v, 8'h41);
    n0 = slv_got.size();
    wr(3'd2, 8'h12);
    repeat (20) @(posedge clk);
    rd(3'd1, v); chk(v == 8'h81, "R10 flag set, byte held", v, 8'h81);
    chk(slv_got.size() == n0, "R10 no exchange without master", slv_got.size(), n0);
    wr(3'd1, 8'h80);
    rd(3'd1, v); chk(v == 8'h01, "R10 flag cleared", v, 8'h01);
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);
    slv_out.push_back(8'hE7);
    slave_prep();
    wr(3'd0, 8'h51);
    wait_status(8'h01, 8'h00, ok);
    rd(3'd2, v); chk(v == 8'hE7, "R10 held byte exchanged later", v, 8'hE7);
    chk(slv_got.size() == n0 + 1 && slv_got[n0] == 8'h12, "R10 held byte sent", slv_got[n0], 8'h12);

    model_on = 1'b0;
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total + pc_total, bad + pc_bad);
    $finish;
  end

endmodule